// File: doc/BRIEF.md
# Converter Power-State Wake-Up Sequencer

This block sits on the host side of a sampling data converter. It drives the converter's shutdown and standby pins and issues convert-start pulses. It makes sure that no user conversion reaches the converter before the device has settled. After reset, and again after the converter leaves shutdown, it waits for a wake-up interval of about one millisecond. That interval is counted in cycles of the system clock, using the clock frequency given as a parameter. The converter's own clock, which may run anywhere from 1 MHz to 6 MHz, is not used for this count. The sequencer then runs one throw-away conversion. When the converter leaves standby, its reference circuits are still powered, so only the throw-away conversion is needed and there is no timed wait.

The user side is four single-cycle request inputs (sleep, standby, wake and convert) and three outputs:
- a ready level;
- a one-cycle strobe for each real conversion that completes;
- a one-cycle error strobe for any convert request that is refused.

Throw-away conversions never raise the result strobe. End of conversion comes in on a single input. If that input stays silent for too long, a watchdog abandons the conversion and starts a new throw-away conversion.

Top module: `pwr_wake_seq`

## Requirements
- R1: While reset is asserted and during the wake-up wait that follows it, ready, conv_start, shdn_o, stby_o, result_valid and err_pulse are all low. The first conv_start appears exactly WAKE cycles after reset is released. Here WAKE = SYS_CLK_HZ * WAKE_US / 1,000,000, with a minimum of 1.
- R2: Every conversion request to the converter is a conv_start pulse one cycle wide. When eoc arrives during a throw-away conversion, ready rises in the next cycle and result_valid stays low.
- R3: ready is high only when the sequencer is idle and able to accept work. A convert request accepted while ready is high gives conv_start high and ready low in the next cycle.
- R4: When eoc arrives during a user conversion, result_valid is high for exactly one cycle, starting in the next cycle. In that same cycle ready returns, unless a power-down request is pending.
- R5: A convert request that is not accepted gives err_pulse high for one cycle, in the next cycle, and produces no conv_start. A request is not accepted when ready is low, or when a sleep or standby request comes in the same cycle.
- R6: A sleep request while ready is high gives shdn_o high in the next cycle. A wake request in shutdown gives shdn_o low in the next cycle, then a WAKE-cycle wait, then a throw-away conversion. The first conv_start comes WAKE+1 cycles after the wake request is sampled.
- R7: A standby request while ready is high gives stby_o high in the next cycle. A wake request in standby gives stby_o low and conv_start high together in the next cycle.
- R8: A sleep or standby request made during a user conversion is held until eoc. The result strobe is then given, and the pending power state is entered in the same cycle. If both are pending, shutdown is chosen.
- R9: When several requests arrive in one cycle while ready is high, the priority is sleep, then standby, then convert.
- R10: If no eoc arrives within EOC_TMO_CYC cycles of a conv_start, a new throw-away conversion starts in the following cycle. No result_valid is given, and any pending power-down request is dropped.
- R11: Requests that do not apply to the current state are ignored. A wake request while ready, or a sleep or standby request during a throw-away conversion or the wake-up wait, leaves every output unchanged.
- R12: The wake-up wait length follows from the SYS_CLK_HZ and WAKE_US parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_sleep | input | 1 | Request to enter shutdown (one cycle) |
| req_standby | input | 1 | Request to enter standby (one cycle) |
| req_wake | input | 1 | Request to leave shutdown or standby (one cycle) |
| req_convert | input | 1 | Request for a user conversion (one cycle) |
| eoc | input | 1 | End-of-conversion pulse from the converter |
| conv_start | output | 1 | Convert-start pulse to the converter |
| shdn_o | output | 1 | Shutdown pin drive, high in shutdown |
| stby_o | output | 1 | Standby pin drive, high in standby |
| ready | output | 1 | Sequencer idle and accepting requests |
| result_valid | output | 1 | One-cycle strobe for a completed user conversion |
| err_pulse | output | 1 | One-cycle strobe for a refused convert request |

## Verification
The assertions check these cycle-local rules on every cycle:
- conv_start is a single-cycle pulse;
- the two power pins are never high together, and ready is never high with either of them;
- result strobes follow eoc, and error strobes follow convert requests;
- an accepted convert request produces a start pulse;
- leaving standby starts a conversion at once;
- a conversion left without eoc is restarted after the timeout window.

Some properties can only be shown by the bench's scenarios, run against its reference model: the exact length of the wake-up wait after reset and after shutdown, the holding and dropping of pending power-down requests, and the request priority when several requests arrive in one cycle.

// File: rtl/pws_pkg.sv
package pws_pkg;

  typedef enum logic [2:0] {
    ST_RESET_WAIT = 3'd0,
    ST_DUMMY      = 3'd1,
    ST_READY      = 3'd2,
    ST_CONVERTING = 3'd3,
    ST_SHUTDOWN   = 3'd4,
    ST_STANDBY    = 3'd5
  } pws_state_t;

  // Wake-up interval in system clock cycles, never less than one
  function automatic int unsigned wake_cycles(input int unsigned hz, input int unsigned us);
    longint unsigned t;
    t = (longint'(hz) * longint'(us)) / 64'd1_000_000;
    if (t == 64'd0) t = 64'd1;
    return int'(t);
  endfunction

endpackage

// File: rtl/pws_wake_timer.sv
module pws_wake_timer #(
  parameter int unsigned LIMIT = 50_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign done = run && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (!done) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pws_eoc_watchdog.sv
module pws_eoc_watchdog #(
  parameter int unsigned TMO = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic expired
);
  localparam int unsigned CW = $clog2(TMO + 1);
  localparam logic [CW-1:0] LAST = CW'(TMO - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign expired = run && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (restart || !run) cnt_d = '0;
    else if (!expired)   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pws_pend_latch.sv
module pws_pend_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic req_sleep,
  input  logic req_standby,
  output logic pend_sleep,
  output logic pend_standby
);
  logic sl_d, sb_d;

  always_comb begin
    sl_d = 1'b0;
    sb_d = 1'b0;
    if (hold) begin
      sl_d = pend_sleep | req_sleep;
      sb_d = pend_standby | req_standby;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_sleep   <= 1'b0;
      pend_standby <= 1'b0;
    end else begin
      pend_sleep   <= sl_d;
      pend_standby <= sb_d;
    end
  end
endmodule

// File: rtl/pwr_wake_seq.sv
module pwr_wake_seq
  import pws_pkg::*;
#(
  parameter int unsigned SYS_CLK_HZ  = 50_000_000,
  parameter int unsigned WAKE_US     = 1000,
  parameter int unsigned EOC_TMO_CYC = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_sleep,
  input  logic req_standby,
  input  logic req_wake,
  input  logic req_convert,
  input  logic eoc,
  output logic conv_start,
  output logic shdn_o,
  output logic stby_o,
  output logic ready,
  output logic result_valid,
  output logic err_pulse
);
  localparam int unsigned WAKE_CYC = wake_cycles(SYS_CLK_HZ, WAKE_US);

  pws_state_t st_q, st_d;
  logic launch;
  logic wake_done, tmo;
  logic pend_sleep, pend_standby;
  logic start_q, valid_q, err_q;
  logic valid_d, err_d;
  logic busy;
  logic accept_conv;

  assign busy = (st_q == ST_DUMMY) || (st_q == ST_CONVERTING);

  pws_wake_timer #(.LIMIT(WAKE_CYC)) u_wake (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (st_q == ST_RESET_WAIT),
    .done (wake_done)
  );

  pws_eoc_watchdog #(.TMO(EOC_TMO_CYC)) u_wdg (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(launch),
    .run    (busy),
    .expired(tmo)
  );

  pws_pend_latch u_pend (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold        (st_q == ST_CONVERTING),
    .req_sleep   (req_sleep),
    .req_standby (req_standby),
    .pend_sleep  (pend_sleep),
    .pend_standby(pend_standby)
  );

  assign accept_conv = (st_q == ST_READY) && !req_sleep && !req_standby;

  // Next-state process
  always_comb begin
    st_d   = st_q;
    launch = 1'b0;
    unique case (st_q)
      ST_RESET_WAIT: begin
        if (wake_done) begin
          st_d   = ST_DUMMY;
          launch = 1'b1;
        end
      end
      ST_DUMMY: begin
        if (eoc) begin
          st_d = ST_READY;
        end else if (tmo) begin
          st_d   = ST_DUMMY;
          launch = 1'b1;
        end
      end
      ST_READY: begin
        if (req_sleep)        st_d = ST_SHUTDOWN;
        else if (req_standby) st_d = ST_STANDBY;
        else if (req_convert) begin
          st_d   = ST_CONVERTING;
          launch = 1'b1;
        end
      end
      ST_CONVERTING: begin
        if (eoc) begin
          if (pend_sleep || req_sleep)          st_d = ST_SHUTDOWN;
          else if (pend_standby || req_standby) st_d = ST_STANDBY;
          else                                  st_d = ST_READY;
        end else if (tmo) begin
          st_d   = ST_DUMMY;
          launch = 1'b1;
        end
      end
      ST_SHUTDOWN: begin
        if (req_wake) st_d = ST_RESET_WAIT;
      end
      ST_STANDBY: begin
        if (req_wake) begin
          st_d   = ST_DUMMY;
          launch = 1'b1;
        end
      end
      default: st_d = ST_RESET_WAIT;
    endcase
  end

  assign valid_d = (st_q == ST_CONVERTING) && eoc;
  assign err_d   = req_convert && !accept_conv;

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_RESET_WAIT;
      start_q <= 1'b0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      start_q <= launch;
      valid_q <= valid_d;
      err_q   <= err_d;
    end
  end

  assign conv_start   = start_q;
  assign result_valid = valid_q;
  assign err_pulse    = err_q;
  assign ready        = (st_q == ST_READY);
  assign shdn_o       = (st_q == ST_SHUTDOWN);
  assign stby_o       = (st_q == ST_STANDBY);

endmodule

// File: rtl/pwr_wake_seq_chk.sv
module pwr_wake_seq_chk #(
  parameter int unsigned EOC_TMO_CYC = 4096
) (
  input logic clk,
  input logic rst_n,
  input logic req_sleep,
  input logic req_standby,
  input logic req_wake,
  input logic req_convert,
  input logic eoc,
  input logic conv_start,
  input logic shdn_o,
  input logic stby_o,
  input logic ready,
  input logic result_valid,
  input logic err_pulse
);
  localparam int unsigned AW = $clog2(EOC_TMO_CYC + 2);
  localparam logic [AW-1:0] AMAX = AW'(EOC_TMO_CYC);

  logic [AW-1:0] age_q;
  logic          outs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q  <= '0;
      outs_q <= 1'b0;
    end else begin
      if (conv_start)         age_q <= AW'(1);
      else if (age_q != AMAX) age_q <= age_q + 1'b1;
      if (conv_start)         outs_q <= !eoc;
      else if (eoc)           outs_q <= 1'b0;
    end
  end

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R2
  AST_READY_NOT_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (!shdn_o && !stby_o && !conv_start)); // R3
  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && req_convert && !req_sleep && !req_standby) |=> (conv_start && !ready)); // R3
  AST_VALID_FOLLOWS_EOC: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> $past(eoc)); // R4
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid); // R4
  AST_ERR_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(req_convert)); // R5
  AST_PINS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(shdn_o && stby_o)); // R6
  AST_SHDN_EXIT_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shdn_o) |-> (!conv_start && !ready)); // R6
  AST_STBY_EXIT_DUMMY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stby_o) |-> conv_start); // R7
  AST_TMO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (outs_q && age_q == AMAX) |-> conv_start); // R10
  AST_WAKE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && req_wake && !req_convert && !req_sleep && !req_standby) |=> ready); // R11
endmodule

bind pwr_wake_seq pwr_wake_seq_chk #(.EOC_TMO_CYC(EOC_TMO_CYC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_sleep   (req_sleep),
  .req_standby (req_standby),
  .req_wake    (req_wake),
  .req_convert (req_convert),
  .eoc         (eoc),
  .conv_start  (conv_start),
  .shdn_o      (shdn_o),
  .stby_o      (stby_o),
  .ready       (ready),
  .result_valid(result_valid),
  .err_pulse   (err_pulse)
);

// File: tb/tb_pwr_wake_seq.sv
module tb_pwr_wake_seq;
  localparam int SYS_HZ = 20_000;
  localparam int WUS    = 1000;
  localparam int TMO    = 16;
  localparam int W      = SYS_HZ * WUS / 1_000_000;  // 20 cycles

  localparam int M_RW = 0, M_DUM = 1, M_RDY = 2, M_CONV = 3, M_SHD = 4, M_STB = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_sleep = 1'b0, req_standby = 1'b0, req_wake = 1'b0, req_convert = 1'b0;
  logic eoc = 1'b0;
  logic conv_start, shdn_o, stby_o, ready, result_valid, err_pulse;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int eoc_lat = 3;
  int eoc_cd = 0;
  bit mute = 1'b0;

  always #10 clk = ~clk;

  pwr_wake_seq #(.SYS_CLK_HZ(SYS_HZ), .WAKE_US(WUS), .EOC_TMO_CYC(TMO)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_sleep(req_sleep), .req_standby(req_standby), .req_wake(req_wake),
    .req_convert(req_convert), .eoc(eoc),
    .conv_start(conv_start), .shdn_o(shdn_o), .stby_o(stby_o), .ready(ready),
    .result_valid(result_valid), .err_pulse(err_pulse)
  );

  // Behavioural reference model
  int m_st = M_RW, m_wait = 0, m_age = 0;
  bit m_ps = 0, m_pb = 0;
  bit e_start = 0, e_valid = 0, e_err = 0;

  always @(posedge clk or negedge rst_n) begin
    int nxt;
    if (!rst_n) begin
      m_st = M_RW; m_wait = 0; m_age = 0; m_ps = 0; m_pb = 0;
      e_start = 0; e_valid = 0; e_err = 0;
    end else begin
      e_err   = req_convert && !(m_st == M_RDY && !req_sleep && !req_standby);
      e_start = 0;
      e_valid = 0;
      nxt = m_st;
      if (m_st == M_RW) begin
        m_wait++;
        if (m_wait == W) begin nxt = M_DUM; e_start = 1; end
      end else if (m_st == M_DUM) begin
        m_age++;
        if (eoc) nxt = M_RDY;
        else if (m_age == TMO) e_start = 1;
      end else if (m_st == M_RDY) begin
        if (req_sleep) nxt = M_SHD;
        else if (req_standby) nxt = M_STB;
        else if (req_convert) begin nxt = M_CONV; e_start = 1; end
      end else if (m_st == M_CONV) begin
        m_age++;
        if (req_sleep) m_ps = 1;
        if (req_standby) m_pb = 1;
        if (eoc) begin
          e_valid = 1;
          nxt = m_ps ? M_SHD : (m_pb ? M_STB : M_RDY);
        end else if (m_age == TMO) begin
          nxt = M_DUM; e_start = 1;
        end
      end else if (m_st == M_SHD) begin
        if (req_wake) begin nxt = M_RW; m_wait = 0; end
      end else if (m_st == M_STB) begin
        if (req_wake) begin nxt = M_DUM; e_start = 1; end
      end
      if (e_start) m_age = 0;
      if (nxt != M_CONV) begin m_ps = 0; m_pb = 0; end
      m_st = nxt;
    end
  end

  // Converter stub: eoc a fixed delay after each start, unless muted
  always @(negedge clk) begin
    if (!rst_n) begin
      eoc = 1'b0; eoc_cd = 0;
    end else begin
      eoc = 1'b0;
      if (conv_start) eoc_cd = eoc_lat;
      else if (eoc_cd > 0) begin
        eoc_cd--;
        if (eoc_cd == 0 && !mute) eoc = 1'b1;
      end
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      bit bad;
      bad = 0;
      checks++;
      if (ready !== (m_st == M_RDY)) begin bad = 1;
        $display("FAIL R3 ready act=%0b exp=%0b t=%0t", ready, m_st == M_RDY, $time); end
      if (conv_start !== e_start) begin bad = 1;
        $display("FAIL R2 conv_start act=%0b exp=%0b t=%0t", conv_start, e_start, $time); end
      if (result_valid !== e_valid) begin bad = 1;
        $display("FAIL R4 result_valid act=%0b exp=%0b t=%0t", result_valid, e_valid, $time); end
      if (err_pulse !== e_err) begin bad = 1;
        $display("FAIL R5 err_pulse act=%0b exp=%0b t=%0t", err_pulse, e_err, $time); end
      if (shdn_o !== (m_st == M_SHD)) begin bad = 1;
        $display("FAIL R6 shdn_o act=%0b exp=%0b t=%0t", shdn_o, m_st == M_SHD, $time); end
      if (stby_o !== (m_st == M_STB)) begin bad = 1;
        $display("FAIL R7 stby_o act=%0b exp=%0b t=%0t", stby_o, m_st == M_STB, $time); end
      if (bad) errors++;
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100_000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp<=100000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic wait_ready();
    int n = 0;
    while (!ready && n < 2000) begin @(negedge clk); n++; end
    chk(ready === 1'b1, "R2 reach ready", ready, 1);
  endtask

  task automatic convert_once();
    @(negedge clk) req_convert = 1;
    @(negedge clk) req_convert = 0;
    chk(conv_start === 1'b1 && ready === 1'b0, "R3 accept", conv_start, 1);
    while (!result_valid) @(negedge clk);
    chk(ready === 1'b1, "R4 ready with result", ready, 1);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk({ready, conv_start, shdn_o, stby_o, result_valid, err_pulse} === 6'b0, "R1 reset outputs",
        {ready, conv_start, shdn_o, stby_o, result_valid, err_pulse}, 0);
    rst_n = 1'b1;
    // R1 / R12: wake-up wait length after reset
    n = 0;
    do begin @(negedge clk); n++;
      if (!conv_start && (ready || shdn_o || stby_o)) chk(0, "R1 quiet wait", 1, 0);
    end while (!conv_start && n < 1000);
    chk(n == W, "R12 wake wait length", n, W);
    // R11: standby request during dummy ignored
    @(negedge clk) req_standby = 1;
    @(negedge clk) req_standby = 0;
    wait_ready();
    @(negedge clk);
    chk(stby_o === 1'b0 && ready === 1'b1, "R11 standby during dummy ignored", stby_o, 0);

    // R3/R4: conversions with several latencies
    eoc_lat = 1; convert_once();
    eoc_lat = 5; convert_once();
    eoc_lat = 3; convert_once();

    // R11: wake while ready ignored
    @(negedge clk) req_wake = 1;
    @(negedge clk) req_wake = 0;
    chk(ready === 1'b1 && conv_start === 1'b0, "R11 wake ignored", ready, 1);

    // R5: convert during a conversion refused
    @(negedge clk) req_convert = 1;
    @(negedge clk) req_convert = 1;
    chk(err_pulse === 1'b0, "R5 first accepted", err_pulse, 0);
    @(negedge clk) req_convert = 0;
    chk(err_pulse === 1'b1, "R5 refused convert", err_pulse, 1);
    wait_ready();

    // R6: shutdown and wake with wait
    @(negedge clk) req_sleep = 1;
    @(negedge clk) req_sleep = 0;
    chk(shdn_o === 1'b1 && ready === 1'b0, "R6 enter shutdown", shdn_o, 1);
    @(negedge clk) req_convert = 1;
    @(negedge clk) req_convert = 0;
    chk(err_pulse === 1'b1 && conv_start === 1'b0, "R5 convert in shutdown", err_pulse, 1);
    @(negedge clk) req_wake = 1;
    n = 0;
    do begin @(negedge clk); n++; if (n == 1) begin req_wake = 0;
        chk(shdn_o === 1'b0, "R6 leave shutdown", shdn_o, 0); end
    end while (!conv_start && n < 1000);
    chk(n == W + 1, "R6 wait after shutdown", n, W + 1);
    wait_ready();

    // R7: standby exit starts dummy at once
    @(negedge clk) req_standby = 1;
    @(negedge clk) req_standby = 0;
    chk(stby_o === 1'b1, "R7 enter standby", stby_o, 1);
    @(negedge clk) req_wake = 1;
    @(negedge clk) req_wake = 0;
    chk(stby_o === 1'b0 && conv_start === 1'b1, "R7 dummy right away", conv_start, 1);
    @(negedge clk);
    chk(conv_start === 1'b0, "R2 single pulse", conv_start, 0);
    wait_ready();

    // R8: sleep and standby pending during conversion, sleep wins
    eoc_lat = 6;
    @(negedge clk) req_convert = 1;
    @(negedge clk) begin req_convert = 0; req_standby = 1; end
    @(negedge clk) begin req_standby = 0; req_sleep = 1; end
    @(negedge clk) req_sleep = 0;
    chk(shdn_o === 1'b0 && stby_o === 1'b0, "R8 held while converting", shdn_o, 0);
    while (!result_valid) @(negedge clk);
    chk(shdn_o === 1'b1 && ready === 1'b0, "R8 pending shutdown", shdn_o, 1);
    @(negedge clk) req_wake = 1;
    @(negedge clk) req_wake = 0;
    wait_ready();

    // R9: simultaneous requests in ready
    @(negedge clk) begin req_sleep = 1; req_standby = 1; req_convert = 1; end
    @(negedge clk) begin req_sleep = 0; req_standby = 0; req_convert = 0; end
    chk(shdn_o === 1'b1 && stby_o === 1'b0 && err_pulse === 1'b1, "R9 sleep wins", shdn_o, 1);
    @(negedge clk) req_wake = 1;
    @(negedge clk) req_wake = 0;
    wait_ready();
    @(negedge clk) begin req_standby = 1; req_convert = 1; end
    @(negedge clk) begin req_standby = 0; req_convert = 0; end
    chk(stby_o === 1'b1 && conv_start === 1'b0, "R9 standby over convert", stby_o, 1);
    @(negedge clk) req_wake = 1;
    @(negedge clk) req_wake = 0;
    wait_ready();

    // R10: timeout with pending sleep dropped
    mute = 1; eoc_lat = 3;
    @(negedge clk) req_convert = 1;
    @(negedge clk) begin req_convert = 0; req_sleep = 1; end
    @(negedge clk) req_sleep = 0;
    n = 2;
    do begin @(negedge clk); n++;
      if (result_valid) chk(0, "R10 no result on timeout", 1, 0);
    end while (!conv_start && n < 200);
    chk(n == TMO + 1, "R10 restart after window", n, TMO + 1);
    mute = 0;
    wait_ready();
    chk(shdn_o === 1'b0, "R10 pending dropped", shdn_o, 0);
    convert_once();

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule